// File: doc/BRIEF.md
# Valley-Count Switch-On Timing Controller

This block picks the moment to turn the main switch back on in a quasi-resonant power stage. While the switch is off it watches a digitised zero-crossing flag from the auxiliary winding. Each high-to-low transition of that flag marks one ringing valley, and the block counts these transitions. When the count reaches the valley number supplied by an external up/down counter, it raises a one-clock turn-on request and clears its count for the next period.

Ringing just after turn-on could look like crossings. To prevent false triggering, a blanking timer rejects crossings for a fixed number of cycles after every request. A second comparator flag, sampled at the moment of turn-on, chooses between a long and a short blanking length.

A third flag reports output overvoltage. It is only considered while the switch is off. If it stays asserted for a full blanking interval, the block latches a fault. The fault stops all further turn-on requests until reset.

All three comparator flags are asynchronous. Each passes through a two-flop synchroniser before use.

Top module: `valley_switch_ctrl`

## Requirements
- R1: After reset, `turn_on_o` and `fault_o` are 0, the crossing count is 0 and no blanking is active.
- R2: A crossing is one high-to-low transition of `zc_cmp_i`, and each transition adds exactly one to the count. When the count reaches `valley_cnt_i`, `turn_on_o` goes high on the third rising clock edge after the input falls.
- R3: `valley_cnt_i` selects the valley, from 1 to 7. A value of 0 is treated as 1. No request is issued before that many crossings have been counted.
- R4: The crossing count clears with every turn-on request, so the next request needs a full new set of crossings.
- R5: `turn_on_o` is high for exactly one clock cycle per request.
- R6: Crossings that occur while `gate_off_i` is 0 are not counted.
- R7: After a request, crossings are ignored for LONG_BLANK cycles if the synchronised `ring_cmp_i` was 0 at the request, or for SHORT_BLANK cycles if it was 1.
- R8: `fault_o` sets after OV_BLANK consecutive cycles in which the synchronised `ov_cmp_i` is 1 and `gate_off_i` is 1. A shorter run leaves `fault_o` at 0.
- R9: `ov_cmp_i` has no effect while `gate_off_i` is 0.
- R10: `fault_o` stays set until reset, and no turn-on request is issued while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_cmp_i | input | 1 | Zero-crossing comparator flag (asynchronous) |
| ring_cmp_i | input | 1 | Ringing-level comparator flag; 1 selects the short blanking |
| ov_cmp_i | input | 1 | Overvoltage comparator flag (asynchronous) |
| gate_off_i | input | 1 | 1 while the main switch is off |
| valley_cnt_i | input | CNT_W | Valley number at which to switch on |
| turn_on_o | output | 1 | One-cycle turn-on request |
| fault_o | output | 1 | Latched overvoltage fault |

## Verification
The assertions check several rules on every cycle:
- each request lasts a single cycle;
- requests and fault onsets only follow off-time cycles;
- once set, the fault never clears;
- no request coincides with the fault.

Other behaviour needs the bench's scenarios. These cover the valley count for each setting and the exact three-edge latency. They also cover the two blanking lengths, with edges placed inside and outside each window. Finally, they cover the overvoltage run length against its threshold and the effect of the gate-off qualification.

// File: rtl/valley_switch_ctrl.sv
module valley_switch_ctrl #(
  parameter int CNT_W       = 3,
  parameter int LONG_BLANK  = 40,
  parameter int SHORT_BLANK = 10,
  parameter int OV_BLANK    = 16,
  localparam int TW  = $clog2(LONG_BLANK + 1),
  localparam int OVW = $clog2(OV_BLANK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_cmp_i,
  input  logic             ring_cmp_i,
  input  logic             ov_cmp_i,
  input  logic             gate_off_i,
  input  logic [CNT_W-1:0] valley_cnt_i,
  output logic             turn_on_o,
  output logic             fault_o
);

  logic [2:0]       zs;
  logic [1:0]       rs, os;
  logic [CNT_W-1:0] zc_cnt;
  logic [TW-1:0]    blank_tmr;
  logic [OVW-1:0]   ov_cnt;

  wire             fall    = zs[2] & ~zs[1];
  wire [CNT_W-1:0] vc_eff  = (valley_cnt_i == '0) ? CNT_W'(1) : valley_cnt_i;
  wire [CNT_W:0]   cnt_nxt = {1'b0, zc_cnt} + 1'b1;
  wire             accept  = fall & gate_off_i & (blank_tmr == '0) & ~fault_o;
  wire             ov_on   = os[1] & gate_off_i & ~fault_o;
  wire             ov_trip = ov_on & (ov_cnt == OVW'(OV_BLANK - 1));
  wire             fire    = accept & (cnt_nxt >= {1'b0, vc_eff}) & ~ov_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zs <= '0;
      rs <= '0;
      os <= '0;
    end else begin
      zs <= {zs[1:0], zc_cmp_i};
      rs <= {rs[0], ring_cmp_i};
      os <= {os[0], ov_cmp_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_cnt    <= '0;
      blank_tmr <= '0;
      turn_on_o <= 1'b0;
    end else begin
      turn_on_o <= fire;
      if (fire) begin
        zc_cnt    <= '0;
        blank_tmr <= rs[1] ? TW'(SHORT_BLANK) : TW'(LONG_BLANK);
      end else begin
        if (accept && zc_cnt != '1) zc_cnt <= zc_cnt + 1'b1;
        if (blank_tmr != '0) blank_tmr <= blank_tmr - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_cnt  <= '0;
      fault_o <= 1'b0;
    end else begin
      ov_cnt  <= (ov_on && !ov_trip) ? ov_cnt + 1'b1 : '0;
      fault_o <= fault_o | ov_trip;
    end
  end

endmodule

module valley_switch_props (
  input logic clk,
  input logic rst_n,
  input logic gate_off_i,
  input logic turn_on_o,
  input logic fault_o
);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |=> !turn_on_o);

  // R6
  on_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |-> $past(gate_off_i));

  // R9
  fault_in_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(gate_off_i));

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  // R10
  no_on_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !turn_on_o);

endmodule

bind valley_switch_ctrl valley_switch_props u_props (
  .clk(clk), .rst_n(rst_n), .gate_off_i(gate_off_i),
  .turn_on_o(turn_on_o), .fault_o(fault_o)
);

// File: tb/sim_valley_switch_ctrl.sv
module sim_valley_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int OVB = 16;

  logic clk = 0, rst_n = 0;
  logic zc = 0, ring = 0, ov = 0, goff = 0;
  logic [2:0] vc = 3'd1;
  logic ton, flt;
  int checks = 0, errors = 0, on_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  valley_switch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .zc_cmp_i(zc), .ring_cmp_i(ring),
    .ov_cmp_i(ov), .gate_off_i(goff), .valley_cnt_i(vc),
    .turn_on_o(ton), .fault_o(flt)
  );

  always @(negedge clk) if (ton) on_cnt++;

  // {valley setting, ring flag, effective valley}
  localparam logic [2:0] VEC [6][3] = '{
    '{3'd1, 3'd0, 3'd1}, '{3'd3, 3'd1, 3'd3}, '{3'd7, 3'd0, 3'd7},
    '{3'd0, 3'd1, 3'd1}, '{3'd5, 3'd1, 3'd5}, '{3'd2, 3'd0, 3'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk) zc = 1;
    repeat (hi) @(negedge clk);
    zc = 0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(2);
  endtask

  initial begin
    int base;
    do_reset();
    // R1
    chk(ton == 0, "R1 turn_on", ton, 0);
    chk(flt == 0, "R1 fault", flt, 0);

    goff = 1;
    foreach (VEC[i]) begin
      vc = VEC[i][0];
      ring = VEC[i][1][0];
      idle(3);
      base = on_cnt;
      repeat (int'(VEC[i][2]) - 1) pulse(6, 6);
      // R3 / R4: no request before the full count
      chk(on_cnt == base, "R3/R4 early request", on_cnt - base, 0);
      pulse(6, 6);
      // R2 / R5: exactly one request of one cycle
      chk(on_cnt == base + 1, "R2/R5 request count", on_cnt - base, 1);
      idle(50);
    end

    // R2 latency: request on third edge after the fall
    vc = 3'd1;
    ring = 0;
    @(negedge clk) zc = 1;
    idle(5);
    zc = 0;
    idle(2);
    chk(ton == 0, "R2 early latency", ton, 0);
    idle(1);
    chk(ton == 1, "R2 latency", ton, 1);
    idle(1);
    chk(ton == 0, "R5 width", ton, 0);

    // R7 long blanking: an edge about 20 cycles later is ignored
    idle(2);
    base = on_cnt;
    idle(8);
    pulse(6, 6);
    chk(on_cnt == base, "R7 long blank", on_cnt - base, 0);
    idle(40);
    ring = 1;
    idle(3);
    pulse(6, 6);
    chk(on_cnt == base + 1, "R7 after long blank", on_cnt - base, 1);
    // R7 short blanking: an edge 8 cycles after is ignored, one 20 later is accepted
    pulse(1, 4);
    chk(on_cnt == base + 1, "R7 inside short blank", on_cnt - base, 1);
    idle(4);
    pulse(6, 6);
    chk(on_cnt == base + 2, "R7 after short blank", on_cnt - base, 2);
    idle(50);

    // R6: edges during on-time are not counted
    vc = 3'd2;
    goff = 0;
    base = on_cnt;
    pulse(6, 6);
    goff = 1;
    idle(2);
    pulse(6, 6);
    chk(on_cnt == base, "R6 on-time edge ignored", on_cnt - base, 0);
    pulse(6, 6);
    chk(on_cnt == base + 1, "R6 count resumes", on_cnt - base, 1);
    idle(50);

    // R8: a short overvoltage run has no effect
    ov = 1;
    idle(OVB - 4);
    ov = 0;
    idle(4);
    chk(flt == 0, "R8 short run", flt, 0);
    // R9: overvoltage during on-time is ignored
    goff = 0;
    ov = 1;
    idle(3 * OVB);
    chk(flt == 0, "R9 on-time ov", flt, 0);
    // R8: a long run in off-time latches the fault
    goff = 1;
    idle(OVB + 4);
    chk(flt == 1, "R8 fault set", flt, 1);
    ov = 0;
    idle(20);
    chk(flt == 1, "R10 fault held", flt, 1);
    vc = 3'd1;
    base = on_cnt;
    pulse(6, 6);
    pulse(6, 6);
    chk(on_cnt == base, "R10 no request in fault", on_cnt - base, 0);
    do_reset();
    chk(flt == 0, "R1/R10 reset clears fault", flt, 0);
    base = on_cnt;
    pulse(6, 6);
    chk(on_cnt == base + 1, "R1 request after reset", on_cnt - base, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule